// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer. It divides a high-speed clock by N = B*P + A and emits one single-cycle pulse per N input cycles to the phase detector. The division is built the classic pulse-swallow way. A dual-modulus prescaler divides by P or P+1, a 5-bit swallow count A decides how many prescaler cycles use P+1, and a 12-bit main count B sets the number of prescaler cycles in one output period.

The prescaler is a synchronous counter around a divide-by-4/5 core. Four core cycles make one prescaler cycle, and the number of core cycles that divide by 5 sets the ratio. The base modulus is chosen at run time between 16 (ratios 16/17) and 19 (ratios 19/20). New settings arrive through a write strobe. A write with B not greater than A is refused and flagged. Accepted settings wait in a shadow copy and become active only when an output period ends.

Top module: `swallow_fbdiv`

## Requirements
- R1: The output period, measured between successive pulses and from reset release to the first pulse, is exactly N = B*P + A input clock cycles.
- R2: cfg_p19_i = 1 selects base modulus 19 (prescaler 19/20); cfg_p19_i = 0 selects base modulus 16 (prescaler 16/17).
- R3: With A = 0, every prescaler cycle divides by P and the period is B*P.
- R4: In each period the prescaler uses P+1 for the first A prescaler cycles and P for the remaining B-A cycles; the modulus control rises only at the start of a period.
- R5: A setting written during a period does not affect that period; the next full period uses it, so no period mixes old and new settings.
- R6: A write with B <= A sets cfg_err_o one cycle after the strobe and leaves the active and pending settings unchanged; the next accepted write clears cfg_err_o one cycle after its strobe.
- R7: div_o is high for exactly one input cycle per period.
- R8: After reset, div_o and cfg_err_o are low and the divider runs with A = 0, B = 16, P = 16 (N = 256).
- R9: The largest setting, A = 31, B = 4095, P = 19, gives a period of 77836 cycles.
- R10: B = A + 1 is accepted (for example A = 31, B = 32, P = 16 gives 543).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-speed input clock to be divided |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Write strobe for a new setting |
| cfg_a_i | input | 5 | Swallow count A |
| cfg_b_i | input | 12 | Main count B |
| cfg_p19_i | input | 1 | Modulus select: 1 gives P = 19, 0 gives P = 16 |
| div_o | output | 1 | Divided pulse, one cycle per period |
| cfg_err_o | output | 1 | Set by a refused write (B <= A) |

## Verification
Each result has a fixed due cycle. The first pulse is due after exactly N rising edges following reset release. Each later pulse is due N edges after the previous one. The error flag is due one edge after the strobe. A new setting governs only the period that starts after the one in progress. The bench drives and samples on falling edges and counts falling edges between pulse samples, crediting the edge used by a write. So after each write it expects the old N for one interval and the new N for the next, and a refused write must leave two intervals at the old value.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    localparam int A_W = 5;
    localparam int B_W = 12;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic           p19;
    } div_cfg_t;

endpackage

// File: rtl/fbdiv_cfg.sv
module fbdiv_cfg
    import fbdiv_pkg::*;
#(
    parameter int RST_A   = 0,
    parameter int RST_B   = 16,
    parameter bit RST_P19 = 1'b0
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wr_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    input  logic           p19_i,
    input  logic           load_i,
    output div_cfg_t       act_o,
    output logic           err_o
);

    localparam div_cfg_t RST_CFG = {A_W'(RST_A), B_W'(RST_B), RST_P19};

    typedef struct packed {
        div_cfg_t shadow;
        div_cfg_t act;
        logic     err;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    wr_ok;

    assign wr_ok = b_i > B_W'(a_i);

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.act = st_q.shadow;
        end
        if (wr_i) begin
            if (wr_ok) begin
                st_d.shadow = {a_i, b_i, p19_i};
                st_d.err    = 1'b0;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= {RST_CFG, RST_CFG, 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o = st_q.act;
    assign err_o = st_q.err;

    // R6: refused write raises the flag
    p_err_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i && (b_i <= B_W'(a_i)) |=> err_o);

    // R6: accepted write clears the flag
    p_err_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i && (b_i > B_W'(a_i)) |=> !err_o);

    // R6: refused write keeps the pending setting
    p_hold_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i && (b_i <= B_W'(a_i)) |=> $stable(st_q.shadow));

    // R6: the active setting always obeys the ordering rule
    p_act_ordered_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.act.b > B_W'(st_q.act.a));

    // R5: active setting only moves at a period boundary
    p_act_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(st_q.act));

endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler #(
    parameter int P_LO    = 16,
    parameter int P_HI    = 19,
    parameter int CORE_LO = 4,
    parameter int STAGES  = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic p19_i,
    input  logic mc_i,
    output logic tick_o
);

    localparam int K_W     = (STAGES > 1) ? $clog2(STAGES) : 1;
    localparam int N5_W    = K_W + 1;
    localparam int C_W     = $clog2(CORE_LO + 1);
    localparam int BASE_LO = P_LO - CORE_LO * STAGES;
    localparam int BASE_HI = P_HI - CORE_LO * STAGES;

    typedef struct packed {
        logic [C_W-1:0] core;
        logic [K_W-1:0] stage;
    } ps_st_t;

    ps_st_t          st_d, st_q;
    logic [N5_W-1:0] n_five;
    logic            five;
    logic            core_end;
    logic [C_W-1:0]  core_last;

    // number of core cycles that divide by five in this prescaler cycle
    assign n_five    = (p19_i ? N5_W'(BASE_HI) : N5_W'(BASE_LO)) + N5_W'(mc_i);
    assign five      = {1'b0, st_q.stage} < n_five;
    assign core_last = five ? C_W'(CORE_LO) : C_W'(CORE_LO - 1);
    assign core_end  = st_q.core == core_last;
    assign tick_o    = core_end && (st_q.stage == K_W'(STAGES - 1));

    always_comb begin
        st_d = st_q;
        if (core_end) begin
            st_d.core = '0;
            if (st_q.stage == K_W'(STAGES - 1)) begin
                st_d.stage = '0;
            end else begin
                st_d.stage = st_q.stage + 1'b1;
            end
        end else begin
            st_d.core = st_q.core + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: the 4/5 core never counts beyond its longer ratio
    p_core_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.core <= C_W'(CORE_LO));

    // R4: modulus control and select stay fixed inside a prescaler cycle
    p_mc_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_o |=> $stable(mc_i) && $stable(p19_i));

endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow
    import fbdiv_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     tick_i,
    input  div_cfg_t act_i,
    output logic     mc_o,
    output logic     last_o,
    output logic     div_o
);

    typedef struct packed {
        logic [B_W-1:0] cnt;
        logic           div;
    } sw_st_t;

    sw_st_t st_d, st_q;

    assign mc_o   = st_q.cnt < B_W'(act_i.a);
    assign last_o = tick_i && (st_q.cnt == act_i.b - 1'b1);

    always_comb begin
        st_d     = st_q;
        st_d.div = last_o;
        if (tick_i) begin
            if (last_o) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o = st_q.div;

    // R7: single-cycle output pulse
    p_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_o |=> !div_o);

    // R4: the long modulus starts only at the head of a period
    p_mc_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mc_o) |-> st_q.cnt == '0);

    // R1: count stays below B
    p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < act_i.b);

endmodule

// File: rtl/swallow_fbdiv.sv
module swallow_fbdiv
    import fbdiv_pkg::*;
#(
    parameter int P_LO    = 16,
    parameter int P_HI    = 19,
    parameter int RST_A   = 0,
    parameter int RST_B   = 16,
    parameter bit RST_P19 = 1'b0
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           cfg_wr_i,
    input  logic [A_W-1:0] cfg_a_i,
    input  logic [B_W-1:0] cfg_b_i,
    input  logic           cfg_p19_i,
    output logic           div_o,
    output logic           cfg_err_o
);

    div_cfg_t act;
    logic     tick;
    logic     mc;
    logic     last;

    fbdiv_cfg #(
        .RST_A  (RST_A),
        .RST_B  (RST_B),
        .RST_P19(RST_P19)
    ) i_cfg (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .wr_i  (cfg_wr_i),
        .a_i   (cfg_a_i),
        .b_i   (cfg_b_i),
        .p19_i (cfg_p19_i),
        .load_i(last),
        .act_o (act),
        .err_o (cfg_err_o)
    );

    fbdiv_prescaler #(
        .P_LO(P_LO),
        .P_HI(P_HI)
    ) i_prescaler (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .p19_i (act.p19),
        .mc_i  (mc),
        .tick_o(tick)
    );

    fbdiv_swallow i_swallow (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_i(tick),
        .act_i (act),
        .mc_o  (mc),
        .last_o(last),
        .div_o (div_o)
    );

endmodule

// File: tb/test_swallow_fbdiv.sv
module test_swallow_fbdiv;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  a_in = '0;
    logic [11:0] b_in = '0;
    logic        p19_in = 1'b0;
    logic        div;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    swallow_fbdiv i_swallow_fbdiv (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .cfg_wr_i (wr),
        .cfg_a_i  (a_in),
        .cfg_b_i  (b_in),
        .cfg_p19_i(p19_in),
        .div_o    (div),
        .cfg_err_o(err)
    );

    function automatic int n_of(int a, int b, bit p19);
        return b * (p19 ? 19 : 16) + a;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // counts falling edges until the next pulse sample; init credits edges already spent
    task automatic measure(int init, output int cycles);
        int cnt = init;
        bit low_seen = 1'b1;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1 && div) low_seen = 1'b0;
        end while (!div && cnt < 100000);
        cycles = cnt;
        if (init == 0) chk("R7 pulse low after pulse", int'(low_seen), 1);
    endtask

    task automatic write_cfg(int a, int b, bit p19);
        a_in   = 5'(a);
        b_in   = 12'(b);
        p19_in = p19;
        wr     = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        chk("R7 pulse low after pulse", int'(div), 0);
    endtask

    // write a valid setting, then expect one old and one new interval
    task automatic apply(string req, int old_n, int a, int b, bit p19);
        int c;
        write_cfg(a, b, p19);
        chk({req, " error flag clear"}, int'(err), 0);
        measure(1, c);
        chk("R5 old period completes", c, old_n);
        measure(0, c);
        chk(req, c, n_of(a, b, p19));
    endtask

    task automatic t_reset();
        int c;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 div low in reset", int'(div), 0);
        chk("R8 err low in reset", int'(err), 0);
        rst_n = 1'b1;
        measure(0, c);
        chk("R8 R1 first period 256", c, 256);
        measure(0, c);
        chk("R1 second period 256", c, 256);
    endtask

    task automatic t_refused();
        int c;
        write_cfg(10, 10, 1'b0);
        chk("R6 flag after B equal A", int'(err), 1);
        measure(1, c);
        chk("R6 period held", c, n_of(5, 20, 1'b0));
        measure(0, c);
        chk("R6 period still held", c, n_of(5, 20, 1'b0));
        write_cfg(10, 3, 1'b1);
        chk("R6 flag after B below A", int'(err), 1);
        measure(1, c);
        chk("R6 held after B below A", c, n_of(5, 20, 1'b0));
        measure(0, c);
        chk("R6 held twice after B below A", c, n_of(5, 20, 1'b0));
    endtask

    initial begin
        t_reset();
        apply("R1 R4 P16 A5 B20", 256, 5, 20, 1'b0);
        t_refused();
        apply("R6 valid write after refusal", n_of(5, 20, 1'b0), 0, 40, 1'b0);
        chk("R3 A0 period is B*P", n_of(0, 40, 1'b0), 640);
        apply("R2 P19 A7 B30", 640, 7, 30, 1'b1);
        apply("R3 P19 A0 B25", n_of(7, 30, 1'b1), 0, 25, 1'b1);
        apply("R10 B equals A plus 1", n_of(0, 25, 1'b1), 31, 32, 1'b0);
        apply("R9 largest setting", 543, 31, 4095, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual %0d expected %0d", WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule